// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block takes one DMA transfer at a time (a start byte address, a byte count, a load or store code and, for stores, a payload of up to `MAX_BYTES` bytes) and breaks it into memory messages that never cross a cache-line boundary. The first message begins at the start address. It covers the bytes from that address up to the end of its line, or the whole transfer if the transfer is shorter. Every later message starts on a line boundary and covers a full line or whatever bytes are still left.

Messages go out one at a time over a valid/ready port. After each accepted message the block waits for a downstream acknowledge before it works out the next chunk. When the acknowledged byte count reaches the transfer length, it raises a one-cycle completion pulse and becomes ready for the next request.

For stores, the block buffers the payload when it accepts the request. Each message carries its share of those bytes, placed at the lanes that match the message's offset within the line.

Top module: `dma_line_sequencer`

## Requirements
- R1: `req_ready` is high whenever the block is idle. From the acceptance of a load or store with non-zero length until the cycle of its completion pulse, `req_ready` is low, so only one transfer is ever outstanding.
- R2: `req_op` code 0 is a load and code 1 is a store. A request offered with code 2 or 3 is consumed without effect: `req_reject` is high for one cycle in the cycle after the handshake, no message is emitted, and `req_ready` stays high.
- R3: The first message has `msg_addr` equal to the start address. With `off` being the start address modulo `LINE_BYTES`, its `msg_len` is min(length, `LINE_BYTES` − off).
- R4: Every later message has `msg_addr` = start + bytes already acknowledged. That address has a zero line offset, and `msg_len` is min(`LINE_BYTES`, bytes remaining).
- R5: `msg_line_addr` is `msg_addr` with its low log2(`LINE_BYTES`) bits cleared. `msg_store` is 1 for a store transfer and 0 for a load.
- R6: Request byte k is `req_data[8k+7:8k]`. For a store, message lane j (`msg_data[8j+7:8j]`) holds request byte (acknowledged + j − off) for off ≤ j < off + `msg_len`. Every other lane is zero, and every lane of a load message is zero.
- R7: While `msg_valid` is high and `msg_ready` is low, all message fields are held. `msg_valid` drops in the cycle after the handshake, and no further message appears until an acknowledge has been received.
- R8: `ack` has an effect only while an accepted message awaits it. An `ack` during idle or while a message is still offered changes nothing.
- R9: On the acknowledge that brings the acknowledged byte count to the transfer length, `done` is high for exactly one cycle, in the next cycle, and no further message follows.
- R10: A load or store of length zero emits no message and pulses `done` in the cycle after the request handshake.
- R11: Synchronous active-high `rst` leaves `req_ready` high and `msg_valid`, `done` and `req_reject` low, with both byte counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 load, 1 store, 2 and 3 unsupported |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes, at most MAX_BYTES |
| req_data | input | 8*MAX_BYTES | Store payload, byte k at bits 8k+7:8k |
| req_reject | output | 1 | One-cycle pulse for an unsupported request code |
| msg_valid | output | 1 | Memory message offered |
| msg_ready | input | 1 | Downstream queue takes the message |
| msg_addr | output | ADDR_W | Physical byte address of the chunk |
| msg_line_addr | output | ADDR_W | Line-aligned address of the chunk |
| msg_store | output | 1 | 1 for store, 0 for load |
| msg_len | output | CLEN_W | Chunk length in bytes |
| msg_data | output | 8*LINE_BYTES | Store bytes placed at their line lanes |
| ack | input | 1 | Downstream acknowledge of the outstanding message |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The assertions assume that `req_len` never exceeds `MAX_BYTES` and that a transfer does not wrap past the top of the address space. They also assume that `ack` arrives only after the message it answers has been accepted. The bench keeps to all three. It sweeps lengths from 0 to `MAX_BYTES` over every line offset, using start addresses far below the top of a 16-bit space. It raises `ack` as a real acknowledge only after the handshake, and any other `ack` it drives is deliberate, to show that such a pulse is ignored. The acceptance and acknowledge delays vary from chunk to chunk, so the hold and no-early-issue rules are exercised across the sweep.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_SEND = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_t;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;

endpackage

// File: rtl/dmaseq_chunk_calc.sv
module dmaseq_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LEN_W      = 7,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remaining,
  output logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] line_addr,
  output logic [CLEN_W-1:0] chunk_len
);
  localparam int CMP_W = ((LEN_W > CLEN_W) ? LEN_W : CLEN_W) + 1;

  logic [CMP_W-1:0] room;
  logic [CMP_W-1:0] rem_w;
  logic [CMP_W-1:0] pick;

  always_comb begin
    offset    = addr[OFF_W-1:0];
    line_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    // bytes left in this line from the offset onward
    room      = CMP_W'(LINE_BYTES) - CMP_W'(offset);
    rem_w     = CMP_W'(remaining);
    pick      = (rem_w <= room) ? rem_w : room;
    chunk_len = CLEN_W'(pick);
  end

endmodule

// File: rtl/dmaseq_payload_buf.sv
module dmaseq_payload_buf #(
  parameter int MAX_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [8*MAX_BYTES-1:0] wr_flat,
  output logic [7:0]             rd_bytes [MAX_BYTES]
);
  logic [7:0] store_q [MAX_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < MAX_BYTES; k++) begin
        store_q[k] <= wr_flat[8*k +: 8];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < MAX_BYTES; k++) begin
      rd_bytes[k] = store_q[k];
    end
  end

endmodule

// File: rtl/dmaseq_lane_place.sv
module dmaseq_lane_place #(
  parameter int LINE_BYTES = 16,
  parameter int MAX_BYTES  = 64,
  parameter int LEN_W      = 7,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1)
) (
  input  logic [7:0]              src_bytes [MAX_BYTES],
  input  logic                    enable,
  input  logic [LEN_W-1:0]        base,
  input  logic [OFF_W-1:0]        offset,
  input  logic [CLEN_W-1:0]       chunk_len,
  output logic [8*LINE_BYTES-1:0] line_data
);
  localparam int IDX_W = LEN_W + 1;
  localparam int SEL_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int POS_W = CLEN_W + 1;

  for (genvar j = 0; j < LINE_BYTES; j++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic             in_span;

    always_comb begin
      // lane j carries request byte base + (j - offset)
      idx     = IDX_W'(base) + IDX_W'(j) - IDX_W'(offset);
      in_span = (POS_W'(j) >= POS_W'(offset)) &&
                (POS_W'(j) <  POS_W'(offset) + POS_W'(chunk_len));
      if (enable && in_span && (idx < IDX_W'(MAX_BYTES))) begin
        line_data[8*j +: 8] = src_bytes[idx[SEL_W-1:0]];
      end else begin
        line_data[8*j +: 8] = 8'h00;
      end
    end
  end

endmodule

// File: rtl/dma_line_sequencer.sv
module dma_line_sequencer
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int MAX_BYTES  = 64,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [8*MAX_BYTES-1:0]  req_data,
  output logic                    req_reject,
  output logic                    msg_valid,
  input  logic                    msg_ready,
  output logic [ADDR_W-1:0]       msg_addr,
  output logic [ADDR_W-1:0]       msg_line_addr,
  output logic                    msg_store,
  output logic [CLEN_W-1:0]       msg_len,
  output logic [8*LINE_BYTES-1:0] msg_data,
  input  logic                    ack,
  output logic                    done
);
  seq_state_t state;

  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  total_len;
  logic              is_store;
  logic [LEN_W-1:0]  done_cnt;
  logic [LEN_W-1:0]  issued_cnt;

  logic                    msg_valid_q;
  logic [ADDR_W-1:0]       msg_addr_q;
  logic [ADDR_W-1:0]       msg_line_q;
  logic                    msg_store_q;
  logic [CLEN_W-1:0]       msg_len_q;
  logic [8*LINE_BYTES-1:0] msg_data_q;
  logic                    done_q;
  logic                    reject_q;

  logic                    req_fire;
  logic                    op_known;
  logic [ADDR_W-1:0]       chunk_addr;
  logic [LEN_W-1:0]        bytes_left;
  logic [OFF_W-1:0]        chunk_off;
  logic [ADDR_W-1:0]       chunk_line;
  logic [CLEN_W-1:0]       chunk_len;
  logic [7:0]              held_bytes [MAX_BYTES];
  logic [8*LINE_BYTES-1:0] placed;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign op_known  = (req_op == OP_LOAD) || (req_op == OP_STORE);

  always_comb begin
    chunk_addr = start_addr + ADDR_W'(done_cnt);
    bytes_left = total_len - done_cnt;
  end

  dmaseq_chunk_calc #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .LEN_W     (LEN_W)
  ) u_calc (
    .addr     (chunk_addr),
    .remaining(bytes_left),
    .offset   (chunk_off),
    .line_addr(chunk_line),
    .chunk_len(chunk_len)
  );

  dmaseq_payload_buf #(
    .MAX_BYTES(MAX_BYTES)
  ) u_buf (
    .clk     (clk),
    .wr_en   (req_fire && (req_op == OP_STORE) && (req_len != '0)),
    .wr_flat (req_data),
    .rd_bytes(held_bytes)
  );

  dmaseq_lane_place #(
    .LINE_BYTES(LINE_BYTES),
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W)
  ) u_place (
    .src_bytes(held_bytes),
    .enable   (is_store),
    .base     (done_cnt),
    .offset   (chunk_off),
    .chunk_len(chunk_len),
    .line_data(placed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      start_addr  <= '0;
      total_len   <= '0;
      is_store    <= 1'b0;
      done_cnt    <= '0;
      issued_cnt  <= '0;
      msg_valid_q <= 1'b0;
      msg_addr_q  <= '0;
      msg_line_q  <= '0;
      msg_store_q <= 1'b0;
      msg_len_q   <= '0;
      msg_data_q  <= '0;
      done_q      <= 1'b0;
      reject_q    <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      reject_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_fire) begin
            if (!op_known) begin
              reject_q <= 1'b1;
            end else if (req_len == '0) begin
              done_q <= 1'b1;
            end else begin
              start_addr <= req_addr;
              total_len  <= req_len;
              is_store   <= (req_op == OP_STORE);
              done_cnt   <= '0;
              issued_cnt <= '0;
              state      <= ST_PREP;
            end
          end
        end
        ST_PREP: begin
          msg_addr_q  <= chunk_addr;
          msg_line_q  <= chunk_line;
          msg_len_q   <= chunk_len;
          msg_store_q <= is_store;
          msg_data_q  <= placed;
          msg_valid_q <= 1'b1;
          state       <= ST_SEND;
        end
        ST_SEND: begin
          if (msg_ready) begin
            msg_valid_q <= 1'b0;
            issued_cnt  <= issued_cnt + LEN_W'(msg_len_q);
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ack) begin
            done_cnt <= issued_cnt;
            if (issued_cnt == total_len) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_PREP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign msg_valid     = msg_valid_q;
  assign msg_addr      = msg_addr_q;
  assign msg_line_addr = msg_line_q;
  assign msg_store     = msg_store_q;
  assign msg_len       = msg_len_q;
  assign msg_data      = msg_data_q;
  assign done          = done_q;
  assign req_reject    = reject_q;

endmodule

// File: rtl/dmaseq_checker.sv
module dmaseq_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int MAX_BYTES  = 64,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_ready,
  input logic                    req_reject,
  input logic                    msg_valid,
  input logic                    msg_ready,
  input logic [ADDR_W-1:0]       msg_addr,
  input logic [ADDR_W-1:0]       msg_line_addr,
  input logic                    msg_store,
  input logic [CLEN_W-1:0]       msg_len,
  input logic [8*LINE_BYTES-1:0] msg_data,
  input logic                    ack,
  input logic                    done,
  input logic [LEN_W-1:0]        done_cnt
);

  assert_busy_blocks_req_R1: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !req_ready);

  assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    req_reject |-> (!msg_valid && req_ready && !done));

  assert_chunk_in_line_R3: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> ((int'(msg_addr[OFF_W-1:0]) + int'(msg_len)) <= LINE_BYTES) &&
                  (msg_len != '0));

  assert_later_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && (done_cnt != '0)) |-> (msg_addr[OFF_W-1:0] == '0));

  assert_line_addr_R5: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_line_addr <= msg_addr) &&
                  ((msg_addr - msg_line_addr) < ADDR_W'(LINE_BYTES)));

  assert_msg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) &&
      $stable(msg_len) && $stable(msg_store) && $stable(msg_data) &&
      $stable(msg_line_addr)));

  assert_msg_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_valid);

  assert_early_ack_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready && ack) |=> (msg_valid && !done));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && !msg_valid));

endmodule

bind dma_line_sequencer dmaseq_checker #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .MAX_BYTES (MAX_BYTES)
) u_dmaseq_checker (
  .clk          (clk),
  .rst          (rst),
  .req_ready    (req_ready),
  .req_reject   (req_reject),
  .msg_valid    (msg_valid),
  .msg_ready    (msg_ready),
  .msg_addr     (msg_addr),
  .msg_line_addr(msg_line_addr),
  .msg_store    (msg_store),
  .msg_len      (msg_len),
  .msg_data     (msg_data),
  .ack          (ack),
  .done         (done),
  .done_cnt     (done_cnt)
);

// File: tb/tb_dma_line_sequencer.sv
module tb_dma_line_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int LINE_BYTES = 8;
  localparam int MAX_BYTES  = 24;
  localparam int LEN_W      = $clog2(MAX_BYTES + 1);
  localparam int CLEN_W     = $clog2(LINE_BYTES + 1);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                    rst;
  logic                    req_valid;
  logic                    req_ready;
  logic [1:0]              req_op;
  logic [ADDR_W-1:0]       req_addr;
  logic [LEN_W-1:0]        req_len;
  logic [8*MAX_BYTES-1:0]  req_data;
  logic                    req_reject;
  logic                    msg_valid;
  logic                    msg_ready;
  logic [ADDR_W-1:0]       msg_addr;
  logic [ADDR_W-1:0]       msg_line_addr;
  logic                    msg_store;
  logic [CLEN_W-1:0]       msg_len;
  logic [8*LINE_BYTES-1:0] msg_data;
  logic                    ack;
  logic                    done;

  dma_line_sequencer #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .MAX_BYTES (MAX_BYTES)
  ) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .req_reject(req_reject),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_line_addr(msg_line_addr), .msg_store(msg_store),
    .msg_len(msg_len), .msg_data(msg_data),
    .ack(ack), .done(done)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
  endtask

  function automatic logic [7:0] pat(input int t, input int k);
    return 8'(t * 29 + k * 11 + 3);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_transfer(input int t, input int start, input int len,
                              input bit store);
    int acked;
    int nchunks;
    for (int k = 0; k < MAX_BYTES; k++) req_data[8*k +: 8] = pat(t, k);
    req_valid = 1'b1;
    req_op    = store ? 2'd1 : 2'd0;
    req_addr  = ADDR_W'(start);
    req_len   = LEN_W'(len);
    step();
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1, "R10 done after empty request", 64'(done), 64'd1);
      chk(msg_valid == 1'b0, "R10 no message", 64'(msg_valid), 64'd0);
      step();
      chk(done == 1'b0, "R9 single pulse", 64'(done), 64'd0);
      return;
    end
    chk(req_ready == 1'b0, "R1 busy after accept", 64'(req_ready), 64'd0);
    acked   = 0;
    nchunks = 0;
    while (acked < len) begin
      int a, off, rem, cl, d, w;
      logic [63:0] exp_data;
      for (int n = 0; n < 10 && !msg_valid; n++) step();
      a   = start + acked;
      off = a % LINE_BYTES;
      rem = len - acked;
      cl  = (rem < LINE_BYTES - off) ? rem : LINE_BYTES - off;
      exp_data = '0;
      for (int j = 0; j < LINE_BYTES; j++)
        if (store && j >= off && j < off + cl)
          exp_data[8*j +: 8] = pat(t, acked + j - off);
      chk(msg_valid == 1'b1, "R7 message offered", 64'(msg_valid), 64'd1);
      if (acked == 0) begin
        chk(msg_addr == ADDR_W'(a), "R3 first addr", 64'(msg_addr), 64'(a));
        chk(msg_len == CLEN_W'(cl), "R3 first len", 64'(msg_len), 64'(cl));
      end else begin
        chk(msg_addr == ADDR_W'(a), "R4 later addr", 64'(msg_addr), 64'(a));
        chk(msg_len == CLEN_W'(cl), "R4 later len", 64'(msg_len), 64'(cl));
      end
      chk(msg_line_addr == ADDR_W'(a - off), "R5 line addr",
          64'(msg_line_addr), 64'(a - off));
      chk(msg_store == store, "R5 type", 64'(msg_store), 64'(store));
      chk(msg_data == exp_data, "R6 payload lanes", msg_data, exp_data);
      chk(req_ready == 1'b0, "R1 busy mid transfer", 64'(req_ready), 64'd0);
      d = (t + nchunks) % 3;
      for (int i = 0; i < d; i++) begin
        if (i == 0 && (t % 5) == 0) ack = 1'b1;
        step();
        ack = 1'b0;
        chk(msg_valid == 1'b1 && msg_addr == ADDR_W'(a) &&
            msg_len == CLEN_W'(cl) && msg_data == exp_data,
            "R7 held while not ready", 64'(msg_addr), 64'(a));
        chk(done == 1'b0, "R8 early ack ignored", 64'(done), 64'd0);
      end
      msg_ready = 1'b1;
      step();
      msg_ready = 1'b0;
      chk(msg_valid == 1'b0, "R7 drop after handshake", 64'(msg_valid), 64'd0);
      w = (t + 2 * nchunks) % 3 + 1;
      for (int i = 0; i < w; i++) begin
        step();
        chk(msg_valid == 1'b0, "R7 no issue before ack", 64'(msg_valid), 64'd0);
      end
      ack = 1'b1;
      step();
      ack = 1'b0;
      acked += cl;
      nchunks++;
      if (acked == len) begin
        chk(done == 1'b1, "R9 completion pulse", 64'(done), 64'd1);
        chk(req_ready == 1'b1, "R1 ready at completion", 64'(req_ready), 64'd1);
      end else begin
        chk(done == 1'b0, "R9 no early completion", 64'(done), 64'd0);
      end
    end
    step();
    chk(done == 1'b0, "R9 single pulse", 64'(done), 64'd0);
    chk(msg_valid == 1'b0, "R9 nothing after completion", 64'(msg_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
    end
  end

  initial begin
    int t;
    rst       = 1'b1;
    req_valid = 1'b0;
    req_op    = 2'd0;
    req_addr  = '0;
    req_len   = '0;
    req_data  = '0;
    msg_ready = 1'b0;
    ack       = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R11 reset state
    chk(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'd1);
    chk(msg_valid == 1'b0, "R11 no message", 64'(msg_valid), 64'd0);
    chk(done == 1'b0, "R11 no done", 64'(done), 64'd0);
    chk(req_reject == 1'b0, "R11 no reject", 64'(req_reject), 64'd0);

    // R2 unsupported codes
    for (int op = 2; op < 4; op++) begin
      req_valid = 1'b1;
      req_op    = 2'(op);
      req_addr  = 16'h0203;
      req_len   = LEN_W'(5);
      step();
      req_valid = 1'b0;
      chk(req_reject == 1'b1, "R2 reject pulse", 64'(req_reject), 64'd1);
      chk(req_ready == 1'b1, "R2 stays idle", 64'(req_ready), 64'd1);
      for (int i = 0; i < 3; i++) begin
        step();
        chk(msg_valid == 1'b0 && done == 1'b0 && req_reject == 1'b0,
            "R2 no message after reject", 64'(msg_valid), 64'd0);
      end
    end

    // R8 ack while idle
    ack = 1'b1;
    step();
    ack = 1'b0;
    step();
    chk(msg_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1,
        "R8 idle ack ignored", 64'(done), 64'd0);

    // sweep: both types, every offset, every length
    t = 0;
    for (int st = 0; st < 2; st++)
      for (int off = 0; off < LINE_BYTES; off++)
        for (int len = 0; len <= MAX_BYTES; len++) begin
          run_transfer(t, 16'h0100 + (t % 7) * LINE_BYTES + off, len, st == 1);
          t++;
        end

    finished = 1'b1;
    report();
    $finish;
  end

endmodule